// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block holds the modem-control and modem-status registers for one UART channel. A CPU register port writes a control register. Two bits of that register drive the active-low terminal-ready and request-to-send pins, and a loop bit forces both pins inactive. The same port reads a status register that reports the present level of the active-low clear-to-send, data-set-ready and carrier-detect inputs, together with one sticky change flag per input.

Each change flag is set when its input goes from low to high, that is, when the input is deasserted. A read of the status register clears the flags. If a flag sets in the same cycle as the read, it is kept. A separate interrupt-enable register provides one enable bit. When that bit is set, it gates the OR of the change flags onto an interrupt request. The block moves no data stream, so every pin is a plain level with no valid/ready handshake. Reads return data combinationally in the cycle the address is presented.

Register addresses on `reg_addr`: 0 is control (read/write), 1 is status (read-only, read clears), 2 is interrupt enable (read/write), 3 reads zero.

Top module: `modem_hs_regs`

## Requirements
- R1: Control bit 0 set drives `dtr_n` low and control bit 1 set drives `rts_n` low, from the cycle after the write, while loop mode is off.
- R2: After reset, `dtr_n` and `rts_n` are high, `irq` is low, and the status change bits are zero.
- R3: While control bit 4 (loop) is set, `dtr_n` and `rts_n` are both high, whatever bits 0 and 1 hold.
- R4: Status bit 4 is the inverse of `cts_n`, bit 5 is the inverse of `dsr_n`, and bit 7 is the inverse of `dcd_n`. Each one follows its pin after two clock edges of synchronization.
- R5: A low-to-high transition of `cts_n`, `dsr_n` or `dcd_n` sets status bit 0, 1 or 3 respectively, one edge after the synchronized level changes. A high-to-low transition sets nothing.
- R6: A change bit stays set until a status read (`reg_rd` with address 1). The read clears it, but a rising transition detected in the same cycle as the read leaves it set.
- R7: `irq` is high exactly when interrupt-enable bit 3 is set and at least one status change bit is set.
- R8: Control bits 7:5 read as zero, bits 4:0 read back as written. Status bits 2 and 6 read as zero. Interrupt-enable reads back only bit 3. Address 3 reads zero.
- R9: `cts_n`, `dsr_n` and `dcd_n` have no effect on `dtr_n` or `rts_n`. Those pins change only on a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status change bits at address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| dcd_n | input | 1 | Carrier-detect, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The hardest case is a rising input edge that is detected on exactly the clock edge on which a status read clears the change flags. From the ports, that means timing the read strobe two edges after the input toggles, so that it lands on the cycle behind the synchronizer's latency. The bench drives this collision directly with counted edges. It then continues with a long pseudo-random walk of input toggles, reads and writes, checked against a reference model every cycle, which produces many more such overlaps.

// File: rtl/modem_hs_pkg.sv
package modem_hs_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 5;   // stored control bits 4:0
  localparam int NUM_IN = 3;   // cts, dsr, dcd

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_IEN  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  // index of each handshake input in the internal vectors
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_DCD = 2;

  localparam int CTRL_DTR_BIT  = 0;
  localparam int CTRL_RTS_BIT  = 1;
  localparam int CTRL_LOOP_BIT = 4;
  localparam int IEN_MSI_BIT   = 3;
endpackage

// File: rtl/modem_hs_sync.sv
module modem_hs_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 3,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/modem_hs_status.sv
module modem_hs_status #(
  parameter int NUM_IN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] sync_n,    // synchronized active-low pins
  input  logic              stat_rd,
  output logic [NUM_IN-1:0] level,     // asserted (active-high) view
  output logic [NUM_IN-1:0] delta
);
  logic [NUM_IN-1:0] prev_n;
  logic [NUM_IN-1:0] rise;

  assign rise  = sync_n & ~prev_n;     // low-to-high of active-low pin
  assign level = ~sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= '1;
      delta  <= '0;
    end else begin
      prev_n <= sync_n;
      if (stat_rd) delta <= rise;
      else         delta <= delta | rise;
    end
  end

  // R6: a change bit survives until a status read
  a_r6_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((delta & $past(delta)) == $past(delta)));

  // R6: a read without a new edge leaves all change bits clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && rise == '0) |=> delta == '0);

  // R5: a change bit only turns on after a detected rising edge
  a_r5_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((delta & ~$past(delta)) != '0) |-> ((delta & ~$past(delta) & ~$past(rise)) == '0));
endmodule

// File: rtl/modem_hs_ctrl.sv
module modem_hs_ctrl
  import modem_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ien_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              ien_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ien_msi,
  output logic              dtr_n,
  output logic              rts_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_msi <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q  <= ctrl_wdata;
      if (ien_wr)  ien_msi <= ien_wdata;
    end
  end

  logic loop_on;
  assign loop_on = ctrl_q[CTRL_LOOP_BIT];
  assign dtr_n   = ~(ctrl_q[CTRL_DTR_BIT] & ~loop_on);
  assign rts_n   = ~(ctrl_q[CTRL_RTS_BIT] & ~loop_on);

  // R3: loop mode keeps both handshake outputs inactive
  a_r3_loop_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (dtr_n && rts_n));

  // R9: outputs move only after a control write
  a_r9_outputs_need_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(dtr_n) && $stable(rts_n)));
endmodule

// File: rtl/modem_hs_regs.sv
module modem_hs_regs
  import modem_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              irq
);
  logic              ctrl_wr, ien_wr, stat_rd;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ien_msi;
  logic [NUM_IN-1:0] pins_n, sync_n, level, delta;
  logic              unused_wbits;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign ien_wr  = reg_wr && (reg_addr == ADDR_IEN);
  assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);
  assign unused_wbits = ^{reg_wdata[REG_W-1:CTRL_W]};

  assign pins_n[IDX_CTS] = cts_n;
  assign pins_n[IDX_DSR] = dsr_n;
  assign pins_n[IDX_DCD] = dcd_n;

  modem_hs_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_IN), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_n), .dout(sync_n)
  );

  modem_hs_status #(.NUM_IN(NUM_IN)) u_status (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .stat_rd(stat_rd),
    .level(level), .delta(delta)
  );

  modem_hs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ien_wr(ien_wr),
    .ctrl_wdata(reg_wdata[CTRL_W-1:0]), .ien_wdata(reg_wdata[IEN_MSI_BIT]),
    .ctrl_q(ctrl_q), .ien_msi(ien_msi), .dtr_n(dtr_n), .rts_n(rts_n)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_STAT: reg_rdata = {level[IDX_DCD], 1'b0, level[IDX_DSR], level[IDX_CTS],
                              delta[IDX_DCD], 1'b0, delta[IDX_DSR], delta[IDX_CTS]};
      ADDR_IEN:  reg_rdata[IEN_MSI_BIT] = ien_msi;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = ien_msi & (|delta);

  // R7: request holds until a status read or a write to interrupt enable
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_rd && !ien_wr) |=> irq);

  // R2/R7: request cannot be high with no change flag pending
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_addr != ADDR_STAT || (reg_rdata & 8'h0B) != 8'h00));
endmodule

// File: tb/modem_hs_regs_tb_top.sv
module modem_hs_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1;
  logic       dtr_n, rts_n, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  modem_hs_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit [2:0] hist[$];           // newest pin sample at front
  bit [2:0] m_delta;
  bit [4:0] m_ctrl;
  bit       m_ien;

  function automatic bit [2:0] m_level();
    return ~hist[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{3'b111, 3'b111, 3'b111};
      m_delta = 0; m_ctrl = 0; m_ien = 0;
    end else begin
      bit [2:0] up;
      up = hist[1] & ~hist[2];
      if (reg_rd && reg_addr == 2'd1) m_delta = up;
      else m_delta = m_delta | up;
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[4:0];
      if (reg_wr && reg_addr == 2'd2) m_ien = reg_wdata[3];
      hist.push_front({dcd_n, dsr_n, cts_n});
      void'(hist.pop_back());
    end
  end

  function automatic bit [7:0] m_rdata(input bit [1:0] a);
    bit [2:0] lv;
    lv = m_level();
    case (a)
      2'd0: return {3'b000, m_ctrl};
      2'd1: return {lv[2], 1'b0, lv[1], lv[0], m_delta[2], 1'b0, m_delta[1], m_delta[0]};
      2'd2: return {4'b0000, m_ien, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit lp;
      lp = m_ctrl[4];
      check(lp ? "R3 dtr_n" : "R1 dtr_n", dtr_n, lp ? 1 : int'(!m_ctrl[0]));
      check(lp ? "R3 rts_n" : "R1 rts_n", rts_n, lp ? 1 : int'(!m_ctrl[1]));
      check("R7 irq", irq, int'(m_ien && (m_delta != 0)));
      check(reg_addr == 2'd1 ? "R4 status" : "R8 readback", reg_rdata, m_rdata(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input bit [1:0] a, output bit [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit [7:0] v;
    bit [15:0] lfsr = 16'hACE1;
    edges(3);
    rst_n = 1'b1;
    edges(2);
    // R2 reset state
    check("R2 dtr_n", dtr_n, 1); check("R2 rts_n", rts_n, 1); check("R2 irq", irq, 0);
    peek(2'd1, v); check("R2 change bits", v & 8'h0B, 0);

    // R1 control drives outputs
    wr(2'd0, 8'h01); check("R1 dtr low", dtr_n, 0); check("R1 rts high", rts_n, 1);
    wr(2'd0, 8'h03); check("R1 both low", {dtr_n, rts_n}, 0);
    // R3 loop plus R8 readback
    wr(2'd0, 8'hFF); check("R3 loop dtr", dtr_n, 1); check("R3 loop rts", rts_n, 1);
    peek(2'd0, v); check("R8 ctrl readback", v, 8'h1F);
    wr(2'd0, 8'h02);

    // R5 falling edges set nothing, R4 levels, R9 no effect on outputs
    @(negedge clk); cts_n = 0; dsr_n = 0; dcd_n = 0;
    edges(4);
    peek(2'd1, v); check("R4 levels", v & 8'hB0, 8'hB0);
    check("R5 no flag on fall", v & 8'h4F, 0);
    check("R9 dtr unchanged", dtr_n, 1); check("R9 rts unchanged", rts_n, 0);

    // R7 enable and raise cts
    wr(2'd2, 8'hFF); peek(2'd2, v); check("R8 ien readback", v, 8'h08);
    peek(2'd3, v); check("R8 addr3", v, 0);
    @(negedge clk); cts_n = 1;
    edges(4);
    check("R7 irq set", irq, 1);
    rd(2'd1, v); check("R5 cts flag", v & 8'h0B, 8'h01);
    check("R6 read clears irq", irq, 0);

    // R6 read coinciding with edge detection: toggle, 2 edges, read on 3rd
    @(negedge clk); dsr_n = 1;
    @(negedge clk); @(negedge clk);
    reg_addr = 2'd1; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    peek(2'd1, v); check("R6 coinciding edge kept", v & 8'h0B, 8'h02);
    check("R7 irq after collision", irq, 1);
    rd(2'd1, v);
    peek(2'd1, v); check("R6 cleared", v & 8'h0B, 0);

    // pseudo-random walk checked by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] && lfsr[1]) cts_n = ~cts_n;
      if (lfsr[2] && lfsr[3]) dsr_n = ~dsr_n;
      if (lfsr[4] && lfsr[5]) dcd_n = ~dcd_n;
      reg_addr = lfsr[7:6];
      reg_rd   = lfsr[8] & lfsr[9];
      reg_wr   = (lfsr[10:8] == 3'b111) && reg_addr != 2'd1;
      reg_wdata = lfsr[15:8];
    end
    @(negedge clk); reg_rd = 0; reg_wr = 0;
    edges(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule